// File: doc/BRIEF.md
# Timekeeping Register Access over SPI

This block is an SPI target (mode 0, eight-bit words, most significant bit first) that gives an external host byte-wide access to a timekeeping register file. Each transaction opens with a command byte and then an address byte, and continues with any number of data bytes. The timekeeping read command streams register contents out on the data-out line. The timekeeping write command delivers each received byte to the register file. In both cases the address advances by one after every data byte and wraps from 0xFF to 0x00. The host may also send the other commands of the same command set: storage access, status, identity, unlock, watchdog clear and memory clear. These are recognised only so that they can be skipped. They never reach the register file.

The SPI pins are oversampled in the system clock domain. A configurable synchroniser feeds edge detectors, so every register-side strobe is a clean single-cycle pulse on `clk`. The clock must run at least eight times faster than SCK. Chip select must fall at least four system clocks before the first SCK rising edge.

The decoder has six phases:
- `PH_OPCODE` waits for the command byte. It moves to `PH_RD_ADDR` on 0x13, to `PH_WR_ADDR` on 0x12, and to `PH_SKIP` on any other value.
- `PH_RD_ADDR` moves to `PH_RD_DATA` once the address byte is complete.
- `PH_WR_ADDR` moves to `PH_WR_DATA` once the address byte is complete.
- `PH_RD_DATA`, `PH_WR_DATA` and `PH_SKIP` stay where they are until chip select rises.
- Chip select high sends every phase back to `PH_OPCODE`.

Top module: `spi_reg_slave`

## Requirements
- R1: Bits are sampled on the rising SCK edge, most significant bit first, while spi_cs_n is low. The first byte is the command and the second byte is the address.
- R2: Command 0x13 issues reg_rd with reg_addr equal to the header address. The returned byte is shifted out on spi_miso, most significant bit first. Each bit changes only after a falling SCK edge, so it is stable at the following rising edge. The first bit is valid at the first rising edge after the header.
- R3: Command 0x12 produces exactly one reg_wr pulse for every completed data byte, with reg_wdata equal to that byte. The first byte goes to the header address.
- R4: In both read and write bursts, successive data bytes use successive addresses, and the address wraps from 0xFF to 0x00.
- R5: The commands 0x01, 0x02, 0x03, 0x04, 0x05, 0x06, 0x14, 0x32, 0x33, 0x44 and 0x54, and any other value except 0x12 and 0x13, produce no reg_wr and no reg_rd until spi_cs_n rises. spi_miso stays 0 during these transactions.
- R6: Raising spi_cs_n discards any partial byte and makes the next byte a command. An unfinished data byte produces no write.
- R7: spi_miso is 0 during the command and address bytes and while spi_cs_n is high.
- R8: reg_wr and reg_rd each last one clk cycle and are never high together. reg_rdata is taken in the cycle after reg_rd.
- R9: After reset, spi_miso, reg_wr and reg_rd are 0 and the decoder waits for a command.
- R10: A write transaction that carries a single data byte is complete and updates that one register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | 8 | Register file address |
| reg_wdata | output | 8 | Register write data |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd |

## Verification
A wrong bit count or a stale shift register shows up at reg_wdata or on spi_miso as a byte rotated by one or more positions. This appears on the first data byte of the transaction. A wrong phase shows up within one byte time as a strobe where none belongs, as nonzero spi_miso during a header, or as a write that lands one address off. Bursts across 0xFF, aborted bytes and every skipped command are driven so that address arithmetic and the return to the command phase are visible in the register contents read back afterwards.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] CMD_TK_READ  = 8'h13;
    localparam logic [BYTE_W-1:0] CMD_TK_WRITE = 8'h12;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_RD_ADDR,
        PH_WR_ADDR,
        PH_RD_DATA,
        PH_WR_DATA,
        PH_SKIP
    } phase_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_rx_byte.sv
module spi_rx_byte
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sample,
    input  logic              bit_in,
    output logic              done,
    output logic [BYTE_W-1:0] byte_o
);
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (clr) begin
            cnt <= '0;
            sh  <= '0;
        end else if (sample) begin
            cnt <= cnt + 1'b1;
            sh  <= {sh[BYTE_W-2:0], bit_in};
        end
    end

    assign done   = sample && !clr && (cnt == CNT_W'(BYTE_W - 1));
    assign byte_o = {sh[BYTE_W-2:0], bit_in};
endmodule

// File: rtl/spi_tx_byte.sv
module spi_tx_byte
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shift,
    output logic              bit_out
);
    logic [BYTE_W-1:0] hold;
    logic              pending;
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold    <= '0;
            pending <= 1'b0;
            sh      <= '0;
        end else if (clr) begin
            pending <= 1'b0;
            sh      <= '0;
        end else begin
            if (shift) begin
                if (pending) begin
                    sh      <= hold;
                    pending <= 1'b0;
                end else begin
                    sh <= {sh[BYTE_W-2:0], 1'b0};
                end
            end
            if (load) begin
                hold    <= load_val;
                pending <= 1'b1;
            end
        end
    end

    assign bit_out = sh[BYTE_W-1];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic [2:0]        pins_s;
    logic              cs_s, sck_s, mosi_s, sck_d;
    logic              sck_rise, sck_fall;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic [BYTE_W-1:0] ptr;
    logic              rd_q;
    logic              tx_bit;
    phase_t            state, state_nxt;

    spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sck, spi_mosi}),
        .q     (pins_s)
    );

    assign {cs_s, sck_s, mosi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign sck_rise = sck_s && !sck_d && !cs_s;
    assign sck_fall = !sck_s && sck_d && !cs_s;

    spi_rx_byte u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cs_s),
        .sample (sck_rise),
        .bit_in (mosi_s),
        .done   (byte_done),
        .byte_o (byte_val)
    );

    spi_tx_byte u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cs_s),
        .load     (rd_q),
        .load_val (reg_rdata),
        .shift    (sck_fall && state == PH_RD_DATA),
        .bit_out  (tx_bit)
    );

    assign spi_miso = (state == PH_RD_DATA) && tx_bit;

    // Phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_OPCODE;
        else        state <= state_nxt;
    end

    // Phase transitions
    always_comb begin
        state_nxt = state;
        if (cs_s) begin
            state_nxt = PH_OPCODE;
        end else if (byte_done) begin
            unique case (state)
                PH_OPCODE: begin
                    if (byte_val == CMD_TK_READ)       state_nxt = PH_RD_ADDR;
                    else if (byte_val == CMD_TK_WRITE) state_nxt = PH_WR_ADDR;
                    else                               state_nxt = PH_SKIP;
                end
                PH_RD_ADDR: state_nxt = PH_RD_DATA;
                PH_WR_ADDR: state_nxt = PH_WR_DATA;
                PH_RD_DATA, PH_WR_DATA, PH_SKIP: state_nxt = state;
                default:    state_nxt = PH_OPCODE;
            endcase
        end
    end

    // Register-side outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            ptr       <= '0;
            rd_q      <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            rd_q   <= reg_rd;
            if (!cs_s && byte_done) begin
                unique case (state)
                    PH_RD_ADDR: begin
                        reg_addr <= byte_val;
                        ptr      <= byte_val + 1'b1;
                        reg_rd   <= 1'b1;
                    end
                    PH_RD_DATA: begin
                        reg_addr <= ptr;
                        ptr      <= ptr + 1'b1;
                        reg_rd   <= 1'b1;
                    end
                    PH_WR_ADDR: ptr <= byte_val;
                    PH_WR_DATA: begin
                        reg_addr  <= ptr;
                        reg_wdata <= byte_val;
                        ptr       <= ptr + 1'b1;
                        reg_wr    <= 1'b1;
                    end
                    PH_OPCODE, PH_SKIP: ;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
    import spi_reg_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   cs_s,
    input phase_t state,
    input logic   reg_wr,
    input logic   reg_rd,
    input logic   spi_miso
);
    assert_wr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    assert_header_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {PH_OPCODE, PH_RD_ADDR, PH_WR_ADDR}) |-> !spi_miso);

    assert_skip_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_SKIP) |=> (state inside {PH_SKIP, PH_OPCODE}));

    assert_skip_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_SKIP) |=> (!reg_wr && !reg_rd && !spi_miso));

    assert_deselect_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (state == PH_OPCODE && !reg_wr && !reg_rd));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .state    (state),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .spi_miso (spi_miso)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_wr, reg_rd;

    logic [7:0] mem [256];
    int         n_chk = 0, n_err = 0;
    int         wr_cnt = 0, rd_cnt = 0, overlap_cnt = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    spi_reg_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   (sck),
        .spi_cs_n  (cs_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

    // Register file model: write on strobe, registered read
    always @(negedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
        if (reg_wr && reg_rd) overlap_cnt <= overlap_cnt + 1;
    end

    always @(posedge clk) if (reg_rd) reg_rdata <= mem[reg_addr];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_bits(input logic [7:0] v, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = v[i];
            repeat (HALF) @(negedge clk);
            rx = {rx[6:0], miso};
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic spi_write(input logic [7:0] a, input logic [7:0] d [], output logic [7:0] hdr_or);
        logic [7:0] rx;
        cs_begin();
        spi_bits(8'h12, 8, rx); hdr_or = rx;
        spi_bits(a, 8, rx);     hdr_or |= rx;
        foreach (d[i]) spi_bits(d[i], 8, rx);
        cs_end();
    endtask

    task automatic spi_read(input logic [7:0] a, input int n, output logic [7:0] q [], output logic [7:0] hdr_or);
        logic [7:0] rx;
        q = new[n];
        cs_begin();
        spi_bits(8'h13, 8, rx); hdr_or = rx;
        spi_bits(a, 8, rx);     hdr_or |= rx;
        for (int i = 0; i < n; i++) spi_bits(8'h00, 8, q[i]);
        cs_end();
    endtask

    task automatic t_reset();
        check("R9 miso after reset", miso, 0);
        check("R9 reg_wr after reset", reg_wr, 0);
        check("R9 reg_rd after reset", reg_rd, 0);
    endtask

    task automatic t_single_write();
        logic [7:0] h; int w0 = wr_cnt;
        spi_write(8'h05, '{8'hA5}, h);
        check("R10 single byte stored", mem[8'h05], 8'hA5);
        check("R3 one strobe per byte", wr_cnt - w0, 1);
        check("R7 miso quiet in write header", h, 0);
    endtask

    task automatic t_burst_write();
        logic [7:0] h; int w0 = wr_cnt;
        spi_write(8'h20, '{8'h11, 8'h22, 8'h33}, h);
        check("R3 burst byte 0", mem[8'h20], 8'h11);
        check("R4 burst byte 1", mem[8'h21], 8'h22);
        check("R4 burst byte 2", mem[8'h22], 8'h33);
        check("R3 three strobes", wr_cnt - w0, 3);
    endtask

    task automatic t_wrap_write();
        logic [7:0] h;
        spi_write(8'hFF, '{8'h5A, 8'hC3}, h);
        check("R4 write at 0xFF", mem[8'hFF], 8'h5A);
        check("R4 write wraps to 0x00", mem[8'h00], 8'hC3);
    endtask

    task automatic t_burst_read();
        logic [7:0] q []; logic [7:0] h;
        spi_read(8'h20, 3, q, h);
        check("R7 miso quiet in read header", h, 0);
        check("R2 read byte 0", q[0], 8'h11);
        check("R4 read byte 1", q[1], 8'h22);
        check("R4 read byte 2", q[2], 8'h33);
        spi_read(8'h05, 1, q, h);
        check("R2 single read", q[0], 8'hA5);
    endtask

    task automatic t_wrap_read();
        logic [7:0] q []; logic [7:0] h;
        spi_read(8'hFF, 2, q, h);
        check("R4 read at 0xFF", q[0], 8'h5A);
        check("R4 read wraps to 0x00", q[1], 8'hC3);
    endtask

    task automatic t_ignored();
        logic [7:0] ops [11] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
                                 8'h14, 8'h32, 8'h33, 8'h44, 8'h54};
        logic [7:0] rx, acc;
        logic [7:0] q []; logic [7:0] h;
        int w0 = wr_cnt, r0 = rd_cnt;
        acc = '0;
        foreach (ops[k]) begin
            cs_begin();
            spi_bits(ops[k], 8, rx); acc |= rx;
            spi_bits(8'h05, 8, rx);  acc |= rx;
            spi_bits(8'hFF, 8, rx);  acc |= rx;
            spi_bits(8'h00, 8, rx);  acc |= rx;
            cs_end();
        end
        check("R5 no writes from other commands", wr_cnt - w0, 0);
        check("R5 no reads from other commands", rd_cnt - r0, 0);
        check("R5 miso quiet for other commands", acc, 0);
        spi_read(8'h05, 1, q, h);
        check("R5 register untouched", q[0], 8'hA5);
    endtask

    task automatic t_abort();
        logic [7:0] rx; logic [7:0] h;
        int w0 = wr_cnt;
        cs_begin();
        spi_bits(8'h12, 8, rx);
        spi_bits(8'h30, 8, rx);
        spi_bits(8'h77, 8, rx);
        spi_bits(8'hFF, 5, rx);
        cs_end();
        check("R6 completed byte kept", mem[8'h30], 8'h77);
        check("R6 partial byte dropped", mem[8'h31], 8'h00);
        check("R6 single strobe", wr_cnt - w0, 1);
        spi_write(8'h31, '{8'h9C}, h);
        check("R6 next transaction realigned", mem[8'h31], 8'h9C);
        check("R1 header byte order", mem[8'h32], 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        reg_rdata = 8'h00;
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_single_write();
        t_burst_write();
        t_wrap_write();
        t_burst_read();
        t_wrap_read();
        t_ignored();
        t_abort();
        check("R8 strobes never overlap", overlap_cnt, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule